// File: doc/BRIEF.md
# Four-Entry Operand Stack Calculator

This block evaluates expressions written in postfix (reverse-Polish) form. It holds four 16-bit registers arranged as a shifting stack, and an arithmetic/logic unit is wired permanently to the two uppermost entries. Each clock edge accepts one command: place a value on the stack, discard the uppermost value, overwrite the uppermost value, or apply an operation selected by a 5-bit function code. The uppermost entry (`top`) and the one beneath it (`next`) are always visible on the outputs.

A two-operand operation takes `next` as its left operand and `top` as its right operand. The result lands in `top`, and the stack closes up by one place. A one-operand operation rewrites `top` and leaves every other entry alone. The block can run on its own as a calculator, or it can sit inside a stack-machine datapath. In that case a sequencer outside the block supplies the commands.

Top module: `opstk_unit`

## Requirements
- R1: After reset, all four entries hold 0. With no pushes, repeated pops keep `top` and `next` at 0.
- R2: The command field `cmd_i` is 3 bits. 0 = idle, 1 = push, 2 = pop, 3 = load, 4 = operate. Codes 5 to 7 act as idle, and only one command is taken per clock.
- R3: On push, `data_i` becomes `top` and each entry moves down one place. The old bottom entry is lost, so after five pushes the first value cannot be recovered.
- R4: On pop, each entry moves up one place and the bottom entry keeps its old value, so it is duplicated.
- R5: On load, `data_i` replaces `top` and all other entries are unchanged.
- R6: Function codes 0x00 to 0x0F are two-operand operations. The result is `next` op `top` and goes into `top`. The remaining entries move up one place, with the bottom entry duplicated.
- R7: Code 0x00 is addition, 0x01 is subtraction and 0x02 is multiplication. All three use 16-bit two's complement, and multiplication keeps the low 16 bits. The postfix sequence 3 4 5 MUL ADD leaves 23.
- R8: Code 0x03 shifts `next` left and code 0x04 shifts it right logically. The shift amount is `top` read as unsigned, and an amount of 16 or more gives 0.
- R9: Code 0x05 is bitwise AND, 0x06 is bitwise OR and 0x07 is bitwise XOR.
- R10: Code 0x08 is logical AND and 0x09 is logical OR. Codes 0x0A to 0x0F are the signed comparisons EQ, NE, GE, LE, GT and LT, in that order. Each of these returns exactly 1 for true and 0 for false.
- R11: Code 0x10 negates `top` arithmetically, 0x11 inverts it bitwise and 0x12 gives its logical NOT. None of these changes `next` or any lower entry.
- R12: An operate command with a function code of 0x13 to 0x1F leaves all four entries unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_i | input | 3 | Command code (R2) |
| data_i | input | 16 | Value for push and load |
| func_i | input | 5 | Function code for operate |
| top_o | output | 16 | Uppermost stack entry |
| next_o | output | 16 | Second stack entry |

## Verification
The hardest behaviour to reach from the ports is what happens to the two entries that are not visible. These are the bottom entry lost on the fifth push and the bottom entry duplicated by a pop or a two-operand operation. The bench fills the stack with distinct values, pushes once more, and then pops repeatedly. This brings each hidden entry up into `next` and `top`. The sequence shows which value was lost and that the final entries repeat. For a two-operand operation, the bench pops after the fold so that the closed-up order can be read out at the ports.

// File: rtl/opstk_pkg.sv
// Package: shared command codes, function codes and stack actions for
// the operand stack calculator. Assumes a 3-bit command and 5-bit function.
package opstk_pkg;

    localparam int CMD_W  = 3;
    localparam int FUNC_W = 5;

    localparam logic [CMD_W-1:0] CMD_IDLE = 3'd0;
    localparam logic [CMD_W-1:0] CMD_PUSH = 3'd1;
    localparam logic [CMD_W-1:0] CMD_POP  = 3'd2;
    localparam logic [CMD_W-1:0] CMD_LOAD = 3'd3;
    localparam logic [CMD_W-1:0] CMD_OPER = 3'd4;

    localparam logic [FUNC_W-1:0] F_ADD  = 5'h00;
    localparam logic [FUNC_W-1:0] F_SUB  = 5'h01;
    localparam logic [FUNC_W-1:0] F_MUL  = 5'h02;
    localparam logic [FUNC_W-1:0] F_SHL  = 5'h03;
    localparam logic [FUNC_W-1:0] F_SHR  = 5'h04;
    localparam logic [FUNC_W-1:0] F_AND  = 5'h05;
    localparam logic [FUNC_W-1:0] F_OR   = 5'h06;
    localparam logic [FUNC_W-1:0] F_XOR  = 5'h07;
    localparam logic [FUNC_W-1:0] F_LAND = 5'h08;
    localparam logic [FUNC_W-1:0] F_LOR  = 5'h09;
    localparam logic [FUNC_W-1:0] F_EQ   = 5'h0A;
    localparam logic [FUNC_W-1:0] F_NE   = 5'h0B;
    localparam logic [FUNC_W-1:0] F_GE   = 5'h0C;
    localparam logic [FUNC_W-1:0] F_LE   = 5'h0D;
    localparam logic [FUNC_W-1:0] F_GT   = 5'h0E;
    localparam logic [FUNC_W-1:0] F_LT   = 5'h0F;
    localparam logic [FUNC_W-1:0] F_NEG  = 5'h10;
    localparam logic [FUNC_W-1:0] F_BNOT = 5'h11;
    localparam logic [FUNC_W-1:0] F_LNOT = 5'h12;

    // first unary code and last valid code
    localparam logic [FUNC_W-1:0] F_UNARY_FIRST = F_NEG;
    localparam logic [FUNC_W-1:0] F_LAST_VALID  = F_LNOT;

    typedef enum logic [2:0] {
        ACT_HOLD,   // keep all entries
        ACT_PUSH,   // shift down, new value on top
        ACT_POP,    // shift up, bottom duplicated
        ACT_WTOP,   // rewrite top only
        ACT_FOLD    // rewrite top, shift lower entries up
    } stk_act_t;

endpackage

// File: rtl/opstk_alu.sv
// Module: combinational operator on the two uppermost stack entries.
// Assumes lhs = next and rhs = top; unary codes use rhs only. Invalid
// codes return zero (the controller never commits them).
module opstk_alu
    import opstk_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0]      lhs_i,
    input  logic [W-1:0]      rhs_i,
    input  logic [FUNC_W-1:0] func_i,
    output logic [W-1:0]      res_o
);
    localparam int SHW = $clog2(W);

    logic signed [W-1:0] lhs_s;
    logic signed [W-1:0] rhs_s;
    logic                big_shift;
    logic [SHW-1:0]      shamt;
    logic                lhs_nz;
    logic                rhs_nz;

    // widen a truth value to a full word holding 0 or 1
    function automatic logic [W-1:0] as_word(input logic b);
        as_word = {{(W-1){1'b0}}, b};
    endfunction

    assign lhs_s     = $signed(lhs_i);
    assign rhs_s     = $signed(rhs_i);
    assign big_shift = |rhs_i[W-1:SHW];
    assign shamt     = rhs_i[SHW-1:0];
    assign lhs_nz    = |lhs_i;
    assign rhs_nz    = |rhs_i;

    // select result for the requested function
    always_comb begin
        unique case (func_i)
            F_ADD:   res_o = lhs_i + rhs_i;
            F_SUB:   res_o = lhs_i - rhs_i;
            F_MUL:   res_o = lhs_i * rhs_i;
            F_SHL:   res_o = big_shift ? '0 : (lhs_i << shamt);
            F_SHR:   res_o = big_shift ? '0 : (lhs_i >> shamt);
            F_AND:   res_o = lhs_i & rhs_i;
            F_OR:    res_o = lhs_i | rhs_i;
            F_XOR:   res_o = lhs_i ^ rhs_i;
            F_LAND:  res_o = as_word(lhs_nz && rhs_nz);
            F_LOR:   res_o = as_word(lhs_nz || rhs_nz);
            F_EQ:    res_o = as_word(lhs_i == rhs_i);
            F_NE:    res_o = as_word(lhs_i != rhs_i);
            F_GE:    res_o = as_word(lhs_s >= rhs_s);
            F_LE:    res_o = as_word(lhs_s <= rhs_s);
            F_GT:    res_o = as_word(lhs_s >  rhs_s);
            F_LT:    res_o = as_word(lhs_s <  rhs_s);
            F_NEG:   res_o = -rhs_i;
            F_BNOT:  res_o = ~rhs_i;
            F_LNOT:  res_o = as_word(!rhs_nz);
            default: res_o = '0;
        endcase
    end

endmodule

// File: rtl/opstk_ctrl.sv
// Module: decodes command and function code into one stack action and
// the source of the value written to top. Assumes one command per clock;
// unknown commands and invalid function codes become a hold.
module opstk_ctrl
    import opstk_pkg::*;
(
    input  logic [CMD_W-1:0]  cmd_i,
    input  logic [FUNC_W-1:0] func_i,
    output stk_act_t          act_o,
    output logic              use_alu_o
);
    logic func_ok;
    logic func_unary;

    assign func_ok    = (func_i <= F_LAST_VALID);
    assign func_unary = (func_i >= F_UNARY_FIRST);

    // map command to stack action
    always_comb begin
        act_o     = ACT_HOLD;
        use_alu_o = 1'b0;
        unique case (cmd_i)
            CMD_PUSH: act_o = ACT_PUSH;
            CMD_POP:  act_o = ACT_POP;
            CMD_LOAD: act_o = ACT_WTOP;
            CMD_OPER: begin
                if (func_ok) begin
                    act_o     = func_unary ? ACT_WTOP : ACT_FOLD;
                    use_alu_o = 1'b1;
                end
            end
            default:  act_o = ACT_HOLD;
        endcase
    end

endmodule

// File: rtl/opstk_regs.sv
// Module: register file of DEPTH shifting entries; entry 0 is top.
// Assumes DEPTH >= 2. Shifting up duplicates the bottom entry; shifting
// down drops it.
module opstk_regs
    import opstk_pkg::*;
#(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  stk_act_t                  act_i,
    input  logic [W-1:0]              wval_i,
    output logic [DEPTH-1:0][W-1:0]   ent_o
);
    localparam int LAST = DEPTH - 1;

    logic [DEPTH-1:0][W-1:0] ent_q;
    logic [DEPTH-1:0][W-1:0] from_above;
    logic [DEPTH-1:0][W-1:0] from_below;

    genvar gi;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_ent
            if (gi == 0) begin : g_first
                assign from_above[gi] = wval_i;
            end else begin : g_rest
                assign from_above[gi] = ent_q[gi-1];
            end

            if (gi == LAST) begin : g_bottom
                assign from_below[gi] = ent_q[gi];
            end else begin : g_upper
                assign from_below[gi] = ent_q[gi+1];
            end

            if (gi == 0) begin : g_top_reg
                // top entry: new value on push/load/fold, lifted on pop
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        ent_q[gi] <= '0;
                    end else begin
                        unique case (act_i)
                            ACT_PUSH, ACT_WTOP, ACT_FOLD: ent_q[gi] <= wval_i;
                            ACT_POP:                      ent_q[gi] <= from_below[gi];
                            default:                      ent_q[gi] <= ent_q[gi];
                        endcase
                    end
                end
            end else begin : g_low_reg
                // lower entry: pushed down or lifted up, else held
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        ent_q[gi] <= '0;
                    end else begin
                        unique case (act_i)
                            ACT_PUSH:          ent_q[gi] <= from_above[gi];
                            ACT_POP, ACT_FOLD: ent_q[gi] <= from_below[gi];
                            default:           ent_q[gi] <= ent_q[gi];
                        endcase
                    end
                end
            end
        end
    endgenerate

    assign ent_o = ent_q;

endmodule

// File: rtl/opstk_unit.sv
// Module: top of the operand stack calculator. Connects decoder, ALU and
// the shifting registers; the ALU reads next and top, and its result or
// the external value is written back. Assumes synchronous active-low reset.
module opstk_unit
    import opstk_pkg::*;
#(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CMD_W-1:0]  cmd_i,
    input  logic [W-1:0]      data_i,
    input  logic [FUNC_W-1:0] func_i,
    output logic [W-1:0]      top_o,
    output logic [W-1:0]      next_o
);
    stk_act_t                act;
    logic                    use_alu;
    logic [W-1:0]            alu_res;
    logic [W-1:0]            wval;
    logic [DEPTH-1:0][W-1:0] ent;

    opstk_ctrl u_ctrl (
        .cmd_i     (cmd_i),
        .func_i    (func_i),
        .act_o     (act),
        .use_alu_o (use_alu)
    );

    opstk_alu #(.W(W)) u_alu (
        .lhs_i  (ent[1]),
        .rhs_i  (ent[0]),
        .func_i (func_i),
        .res_o  (alu_res)
    );

    // choose the value written into top
    assign wval = use_alu ? alu_res : data_i;

    opstk_regs #(.W(W), .DEPTH(DEPTH)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .act_i  (act),
        .wval_i (wval),
        .ent_o  (ent)
    );

    assign top_o  = ent[0];
    assign next_o = ent[1];

endmodule

// File: rtl/opstk_chk.sv
// Module: checker for the operand stack calculator, observing its ports
// across clock edges. Attached to every opstk_unit by the bind below.
module opstk_chk
    import opstk_pkg::*;
#(
    parameter int W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CMD_W-1:0]  cmd_i,
    input logic [W-1:0]      data_i,
    input logic [FUNC_W-1:0] func_i,
    input logic [W-1:0]      top_o,
    input logic [W-1:0]      next_o
);
    logic is_oper;
    logic idle_like;

    assign is_oper   = (cmd_i == CMD_OPER);
    assign idle_like = (cmd_i == CMD_IDLE) || (cmd_i > CMD_OPER);

    AST_PUSH_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_PUSH) |=> (top_o == $past(data_i)) && (next_o == $past(top_o))); // R3

    AST_POP_LIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_POP) |=> (top_o == $past(next_o))); // R4

    AST_LOAD_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_LOAD) |=> (top_o == $past(data_i)) && (next_o == $past(next_o))); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        idle_like |=> $stable(top_o) && $stable(next_o)); // R2

    AST_BAD_FUNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (is_oper && (func_i > F_LAST_VALID)) |=> $stable(top_o) && $stable(next_o)); // R12

    AST_UNARY_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (is_oper && (func_i >= F_UNARY_FIRST) && (func_i <= F_LAST_VALID)) |=> $stable(next_o)); // R11

    AST_BOOL_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (is_oper && (func_i >= F_LAND) && (func_i <= F_LT)) |=> (top_o[W-1:1] == '0)); // R10

    AST_ADD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (is_oper && (func_i == F_ADD)) |=> (top_o == W'($past(next_o) + $past(top_o)))); // R7

endmodule

bind opstk_unit opstk_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd_i  (cmd_i),
    .data_i (data_i),
    .func_i (func_i),
    .top_o  (top_o),
    .next_o (next_o)
);

// File: tb/sim_opstk_unit.sv
// Bench: directed scenarios for opstk_unit, one task each, self-checking.
module sim_opstk_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cmd = 3'd0;
    logic [15:0] data = 16'h0;
    logic [4:0]  func = 5'h0;
    logic [15:0] top_o;
    logic [15:0] next_o;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    opstk_unit u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd_i  (cmd),
        .data_i (data),
        .func_i (func),
        .top_o  (top_o),
        .next_o (next_o)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // drive one command for one clock, return mid-cycle after the edge
    task automatic issue(input logic [2:0] c, input logic [15:0] d, input logic [4:0] f);
        @(negedge clk);
        cmd = c; data = d; func = f;
        @(negedge clk);
        cmd = 3'd0; data = 16'h0; func = 5'h0;
    endtask

    task automatic push(input logic [15:0] d); issue(3'd1, d, 5'h0); endtask
    task automatic pop();                      issue(3'd2, 16'h0, 5'h0); endtask
    task automatic oper(input logic [4:0] f);  issue(3'd4, 16'h0, f); endtask

    task automatic binop(input string req, input logic [15:0] a, input logic [15:0] b,
                         input logic [4:0] f, input logic [15:0] exp);
        push(a);
        push(b);
        oper(f);
        check(req, top_o, exp);
    endtask

    task automatic t_reset();
        check("R1 top after reset", top_o, 16'h0);
        check("R1 next after reset", next_o, 16'h0);
        pop(); pop(); pop();
        check("R1 top after pops", top_o, 16'h0);
        check("R1 next after pops", next_o, 16'h0);
    endtask

    task automatic t_push_pop();
        push(16'd1); push(16'd2); push(16'd3); push(16'd4); push(16'd5);
        check("R3 top after five pushes", top_o, 16'd5);
        check("R3 next after five pushes", next_o, 16'd4);
        pop();
        check("R4 top pop1", top_o, 16'd4);
        check("R4 next pop1", next_o, 16'd3);
        pop();
        check("R4 next pop2", next_o, 16'd2);
        pop();
        check("R3 R4 top pop3 first value lost", top_o, 16'd2);
        check("R4 next pop3 bottom duplicated", next_o, 16'd2);
    endtask

    task automatic t_load();
        push(16'd7); push(16'd9);
        issue(3'd3, 16'h0055, 5'h0);
        check("R5 load top", top_o, 16'h0055);
        check("R5 load next kept", next_o, 16'd7);
    endtask

    task automatic t_fold_order();
        push(16'd10); push(16'd20); push(16'd30); push(16'd40);
        oper(5'h00);
        check("R6 fold top", top_o, 16'd70);
        check("R6 fold next lifted", next_o, 16'd20);
        pop();
        check("R6 fold third lifted", next_o, 16'd10);
        pop();
        check("R6 bottom duplicated top", top_o, 16'd10);
        check("R6 bottom duplicated next", next_o, 16'd10);
    endtask

    task automatic t_postfix();
        push(16'd3); push(16'd4); push(16'd5);
        oper(5'h02);
        check("R7 partial product", top_o, 16'd20);
        check("R7 partial next", next_o, 16'd3);
        oper(5'h00);
        check("R7 postfix result 23", top_o, 16'd23);
    endtask

    task automatic t_arith();
        binop("R7 SUB negative", 16'd3, 16'd5, 5'h01, 16'hFFFE);
        binop("R7 MUL low half", 16'd300, 16'd300, 5'h02, 16'h5F90);
        binop("R7 ADD wrap", 16'hFFFF, 16'd2, 5'h00, 16'h0001);
    endtask

    task automatic t_shift();
        binop("R8 SHL by 4", 16'd1, 16'd4, 5'h03, 16'h0010);
        binop("R8 SHR logical", 16'h8000, 16'd15, 5'h04, 16'h0001);
        binop("R8 SHR by 4", 16'hF000, 16'd4, 5'h04, 16'h0F00);
        binop("R8 SHL by 16 is zero", 16'h00FF, 16'd16, 5'h03, 16'h0000);
    endtask

    task automatic t_bitwise();
        binop("R9 AND", 16'hF0F0, 16'hFF00, 5'h05, 16'hF000);
        binop("R9 OR",  16'hF0F0, 16'hFF00, 5'h06, 16'hFFF0);
        binop("R9 XOR", 16'hF0F0, 16'hFF00, 5'h07, 16'h0FF0);
    endtask

    task automatic t_logic_cmp();
        binop("R10 LAND nonzero", 16'd2, 16'd1, 5'h08, 16'd1);
        binop("R10 LAND zero", 16'd5, 16'd0, 5'h08, 16'd0);
        binop("R10 LOR zero", 16'd0, 16'd0, 5'h09, 16'd0);
        binop("R10 LOR one side", 16'd0, 16'd4, 5'h09, 16'd1);
        binop("R10 EQ", 16'd7, 16'd7, 5'h0A, 16'd1);
        binop("R10 NE", 16'd7, 16'd7, 5'h0B, 16'd0);
        binop("R10 GE signed", 16'hFFFF, 16'd0, 5'h0C, 16'd0);
        binop("R10 LE signed", 16'hFFFF, 16'd1, 5'h0D, 16'd1);
        binop("R10 GT signed", 16'd2, 16'hFFFD, 5'h0E, 16'd1);
        binop("R10 LT signed", 16'h8000, 16'h7FFF, 5'h0F, 16'd1);
    endtask

    task automatic t_unary();
        push(16'd9); push(16'd5);
        oper(5'h10);
        check("R11 NEG", top_o, 16'hFFFB);
        check("R11 NEG keeps next", next_o, 16'd9);
        oper(5'h11);
        check("R11 BNOT", top_o, 16'h0004);
        oper(5'h12);
        check("R11 LNOT nonzero", top_o, 16'h0000);
        oper(5'h12);
        check("R11 LNOT zero", top_o, 16'h0001);
        check("R11 next unchanged", next_o, 16'd9);
    endtask

    task automatic t_hold();
        push(16'd1); push(16'd2);
        oper(5'h13);
        check("R12 func 0x13 top", top_o, 16'd2);
        oper(5'h1F);
        check("R12 func 0x1F next", next_o, 16'd1);
        issue(3'd0, 16'hABCD, 5'h00);
        check("R2 idle top", top_o, 16'd2);
        issue(3'd5, 16'hABCD, 5'h00);
        check("R2 code 5 top", top_o, 16'd2);
        issue(3'd7, 16'hABCD, 5'h00);
        check("R2 code 7 next", next_o, 16'd1);
        pop();
        check("R2 stack intact after ignored codes", top_o, 16'd1);
    endtask

    // watchdog: a hung run is a failed check
    initial begin
        #(20 * 100000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_push_pop();
        t_load();
        t_fold_order();
        t_postfix();
        t_arith();
        t_shift();
        t_bitwise();
        t_logic_cmp();
        t_unary();
        t_hold();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule